// File: doc/BRIEF.md
# Atomic Swap Memory Unit

This block is a byte-addressed storage array placed at a fixed base address in the system map. Each cycle it can accept one request that names an operation, an address, an access size of 1, 2, 4 or 8 bytes, write data, a conditional flag, a compare value and a linked flag. Every request returns a single response pulse after a fixed number of cycles. The response carries the data that was read, or the contents that were there before a swap, together with an error flag.

The swap operation is an atomic read-modify-write. It always returns the contents that were there before it ran. With the conditional flag clear, it always stores the new value. With the flag set, it stores only when the current contents equal the compare value. Invalidate requests complete without touching the array. A read marked as linked also sends out a reservation pulse with its address, so that a neighbouring reservation tracker can record it. Requests are fully pipelined, and a request sees every write made by the requests before it.

The storage size must be a whole number of pages. This is checked when the design is elaborated. When a parameter asks for it, the whole array is cleared to zero during reset.

Top module: `amu_top`

## Requirements
- R1: A read (op code 0) returns the addressed bytes in little-endian order, zero-extended to 64 bits. The size field encodes the access width as 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes and 3 = 8 bytes. A read never changes the array.
- R2: A write (op code 1) stores exactly the number of bytes given by the size field, taken from the low lanes of the write data. Its response data is zero.
- R3: A swap (op code 3) with the conditional flag clear returns the prior contents and always stores the new value, for any of the four sizes.
- R4: A swap with the conditional flag set stores the new value only if the current contents equal the compare value. For a 4-byte access only the low 32 bits of the compare value are used. The prior contents are returned whether or not the store happens.
- R5: A conditional swap of size 1 or 2 bytes gets an error response and leaves the array unchanged.
- R6: An access that is not entirely inside [base, base + size), or whose address is not a multiple of its size, gets an error response, does not write, and returns zero data.
- R7: An invalidate request (op code 2) completes without error, returns zero data and leaves the array unchanged.
- R8: Each request presented in cycle t produces exactly one response pulse in cycle t + LATENCY. Requests can be presented in consecutive cycles, and a later request observes the writes of all earlier ones.
- R9: When zero initialisation is enabled, every byte reads as zero after reset, and no response is pending.
- R10: A read with the linked flag set that completes without error raises the reservation pulse together with its response, carrying the request address. Linked writes, linked swaps and erroneous linked reads raise no reservation pulse.
- R11: The op codes 4 to 7 are unsupported. They get an error response and leave the array unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 3 | Operation: 0 read, 1 write, 2 invalidate, 3 swap |
| req_addr | input | 32 | Byte address |
| req_size | input | 2 | Access size, given as log2 of the byte count |
| req_wdata | input | 64 | Write or swap data, little-endian |
| req_cond | input | 1 | Makes a swap conditional |
| req_cmp | input | 64 | Compare value for a conditional swap |
| req_linked | input | 1 | Marks a read as linked |
| rsp_done | output | 1 | Response pulse |
| rsp_err | output | 1 | The response is an error |
| rsp_data | output | 64 | Read data or prior contents |
| resv_valid | output | 1 | Reservation pulse for a linked read |
| resv_addr | output | 32 | Address of the linked read |

## Verification
The hardest case to reach is a chain of dependent requests issued in consecutive cycles. In such a chain a write, a swap and a conditional swap hit the same bytes while earlier responses are still in the delay line, so each request must see the store made by the request just before it, and the responses must come out in order. The stimulus issues these chains with no idle cycles between requests. It also checks the 4-byte conditional case using a compare value whose upper half is garbage. A reference byte model is updated in issue order, and a cycle stamp on every expected item checks the exact response cycle.

// File: rtl/amu_pkg.sv
package amu_pkg;

    localparam int AMU_AW    = 32;
    localparam int AMU_DW    = 64;
    localparam int AMU_LANES = AMU_DW / 8;

    typedef enum logic [2:0] {
        OP_READ  = 3'd0,
        OP_WRITE = 3'd1,
        OP_INVAL = 3'd2,
        OP_SWAP  = 3'd3
    } amu_op_e;

    typedef struct packed {
        logic              done;
        logic              err;
        logic              resv;
        logic [AMU_AW-1:0] addr;
        logic [AMU_DW-1:0] data;
    } amu_rsp_t;

    // Byte count for a log2-encoded size field.
    function automatic logic [3:0] size_bytes(input logic [1:0] sz);
        return 4'd1 << sz;
    endfunction

    // Address bits that must be zero for a naturally aligned access.
    function automatic logic [2:0] align_mask(input logic [1:0] sz);
        return 3'(size_bytes(sz) - 4'd1);
    endfunction

endpackage

// File: rtl/amu_check.sv
module amu_check
    import amu_pkg::*;
#(
    parameter logic [AMU_AW-1:0] BASE_ADDR = 32'h0000_1000,
    parameter int                MEM_BYTES = 256,
    localparam int               OFF_W     = $clog2(MEM_BYTES)
) (
    input  logic [2:0]        op,
    input  logic [AMU_AW-1:0] addr,
    input  logic [1:0]        size,
    input  logic              cond,
    output logic [OFF_W-1:0]  off,
    output logic              err
);

    logic [AMU_AW:0] rel;
    logic [AMU_AW:0] last;
    logic            below;
    logic            beyond;
    logic            misaligned;
    logic            op_bad;
    logic            cond_bad;

    always_comb begin
        rel        = {1'b0, addr} - {1'b0, BASE_ADDR};
        last       = rel + (AMU_AW+1)'(size_bytes(size));
        below      = addr < BASE_ADDR;
        beyond     = last > (AMU_AW+1)'(MEM_BYTES);
        misaligned = (addr[2:0] & align_mask(size)) != 3'd0;
        op_bad     = op > 3'(OP_SWAP);
        cond_bad   = (op == 3'(OP_SWAP)) && cond && (size < 2'd2);
        err        = below || beyond || misaligned || op_bad || cond_bad;
        off        = rel[OFF_W-1:0];
    end

endmodule

// File: rtl/amu_store.sv
module amu_store
    import amu_pkg::*;
#(
    parameter int  MEM_BYTES = 256,
    parameter bit  ZERO_INIT = 1'b1,
    localparam int OFF_W     = $clog2(MEM_BYTES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [OFF_W-1:0]  off,
    input  logic [1:0]        size,
    input  logic              wen,
    input  logic [AMU_DW-1:0] wdata,
    output logic [AMU_DW-1:0] rdata
);

    logic [7:0] mem [MEM_BYTES];
    logic [3:0] nbytes;

    assign nbytes = size_bytes(size);

    // Read lanes: little-endian, lanes above the access size read as zero.
    for (genvar j = 0; j < AMU_LANES; j++) begin : g_rd_lane
        assign rdata[8*j +: 8] = (4'(j) < nbytes) ? mem[off + OFF_W'(j)] : 8'h00;
    end

    if (ZERO_INIT) begin : g_clear
        always_ff @(posedge clk) begin
            if (rst) begin
                for (int i = 0; i < MEM_BYTES; i++) mem[i] <= 8'h00;
            end else if (wen) begin
                for (int j = 0; j < AMU_LANES; j++)
                    if (4'(j) < nbytes) mem[off + OFF_W'(j)] <= wdata[8*j +: 8];
            end
        end
    end else begin : g_keep
        always_ff @(posedge clk) begin
            if (wen && !rst) begin
                for (int j = 0; j < AMU_LANES; j++)
                    if (4'(j) < nbytes) mem[off + OFF_W'(j)] <= wdata[8*j +: 8];
            end
        end
    end

    // R6: a store reaching the array never runs past its end.
    a_r6_store_in_bounds: assert property (@(posedge clk) disable iff (rst)
        wen |-> (int'(off) + int'(nbytes)) <= MEM_BYTES);

endmodule

// File: rtl/amu_pipe.sv
module amu_pipe
    import amu_pkg::*;
#(
    parameter int LATENCY = 3
) (
    input  logic     clk,
    input  logic     rst,
    input  amu_rsp_t in_rsp,
    output amu_rsp_t out_rsp
);

    amu_rsp_t stg [LATENCY];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < LATENCY; i++) stg[i] <= '0;
        end else begin
            stg[0] <= in_rsp;
            for (int i = 1; i < LATENCY; i++) stg[i] <= stg[i-1];
        end
    end

    assign out_rsp = stg[LATENCY-1];

endmodule

// File: rtl/amu_top.sv
module amu_top
    import amu_pkg::*;
#(
    parameter logic [AMU_AW-1:0] BASE_ADDR  = 32'h0000_1000,
    parameter int                MEM_BYTES  = 256,
    parameter int                PAGE_BYTES = 64,
    parameter int                LATENCY    = 3,
    parameter bit                ZERO_INIT  = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [2:0]        req_op,
    input  logic [AMU_AW-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic [AMU_DW-1:0] req_wdata,
    input  logic              req_cond,
    input  logic [AMU_DW-1:0] req_cmp,
    input  logic              req_linked,
    output logic              rsp_done,
    output logic              rsp_err,
    output logic [AMU_DW-1:0] rsp_data,
    output logic              resv_valid,
    output logic [AMU_AW-1:0] resv_addr
);

    localparam int OFF_W  = $clog2(MEM_BYTES);
    localparam int PEND_W = $clog2(LATENCY + 2);

    if (MEM_BYTES % PAGE_BYTES != 0) begin : g_bad_size
        $error("amu_top: MEM_BYTES must be a whole number of pages");
    end
    if (LATENCY < 1) begin : g_bad_latency
        $error("amu_top: LATENCY must be at least one cycle");
    end

    logic [OFF_W-1:0]  off;
    logic              chk_err;
    logic [AMU_DW-1:0] old_data;
    logic              cmp_hit;
    logic              ok;
    logic              do_write;
    amu_rsp_t          rsp_in;
    amu_rsp_t          rsp_out;

    amu_check #(
        .BASE_ADDR (BASE_ADDR),
        .MEM_BYTES (MEM_BYTES)
    ) u_check (
        .op   (req_op),
        .addr (req_addr),
        .size (req_size),
        .cond (req_cond),
        .off  (off),
        .err  (chk_err)
    );

    amu_store #(
        .MEM_BYTES (MEM_BYTES),
        .ZERO_INIT (ZERO_INIT)
    ) u_store (
        .clk   (clk),
        .rst   (rst),
        .off   (off),
        .size  (req_size),
        .wen   (do_write),
        .wdata (req_wdata),
        .rdata (old_data)
    );

    always_comb begin
        ok       = req_valid && !chk_err;
        cmp_hit  = (req_size == 2'd3) ? (old_data == req_cmp)
                                      : (old_data[31:0] == req_cmp[31:0]);
        do_write = ok && ((req_op == 3'(OP_WRITE)) ||
                          ((req_op == 3'(OP_SWAP)) && (!req_cond || cmp_hit)));

        rsp_in      = '0;
        rsp_in.done = req_valid;
        rsp_in.err  = req_valid && chk_err;
        rsp_in.resv = ok && (req_op == 3'(OP_READ)) && req_linked;
        rsp_in.addr = req_addr;
        if (ok && ((req_op == 3'(OP_READ)) || (req_op == 3'(OP_SWAP))))
            rsp_in.data = old_data;
    end

    amu_pipe #(
        .LATENCY (LATENCY)
    ) u_pipe (
        .clk     (clk),
        .rst     (rst),
        .in_rsp  (rsp_in),
        .out_rsp (rsp_out)
    );

    assign rsp_done   = rsp_out.done;
    assign rsp_err    = rsp_out.err;
    assign rsp_data   = rsp_out.data;
    assign resv_valid = rsp_out.resv;
    assign resv_addr  = rsp_out.addr;

    // Outstanding-request count, kept only for the checks below.
    logic [PEND_W-1:0] pend;
    always_ff @(posedge clk) begin
        if (rst) pend <= '0;
        else     pend <= pend + PEND_W'(req_valid) - PEND_W'(rsp_done);
    end

    // R8: no response without an outstanding request.
    a_r8_no_orphan_done: assert property (@(posedge clk) disable iff (rst)
        rsp_done |-> pend != '0);

    // R8: never more than LATENCY requests in flight.
    a_r8_depth_bound: assert property (@(posedge clk) disable iff (rst)
        int'(pend) <= LATENCY);

    // R10: the reservation pulse only rides on a successful response.
    a_r10_resv_on_ok: assert property (@(posedge clk) disable iff (rst)
        resv_valid |-> (rsp_done && !rsp_err));

    // R6: error responses carry zero data.
    a_r6_err_zero_data: assert property (@(posedge clk) disable iff (rst)
        (rsp_done && rsp_err) |-> rsp_data == '0);

    // R5: a conditional swap that stores is 4 or 8 bytes wide.
    a_r5_cond_width: assert property (@(posedge clk) disable iff (rst)
        (do_write && req_cond && req_op == 3'(OP_SWAP)) |-> req_size >= 2'd2);

endmodule

// File: tb/amu_top_bench.sv
module amu_top_bench;
    import amu_pkg::*;

    localparam logic [31:0] BASE = 32'h0000_1000;
    localparam int          MEM  = 256;
    localparam int          LAT  = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [2:0]  req_op = '0;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic [63:0] req_wdata = '0;
    logic        req_cond = 1'b0;
    logic [63:0] req_cmp = '0;
    logic        req_linked = 1'b0;
    logic        rsp_done;
    logic        rsp_err;
    logic [63:0] rsp_data;
    logic        resv_valid;
    logic [31:0] resv_addr;

    amu_top #(
        .BASE_ADDR (BASE), .MEM_BYTES (MEM), .PAGE_BYTES (64),
        .LATENCY (LAT), .ZERO_INIT (1'b1)
    ) u_amu_top (
        .clk (clk), .rst (rst), .req_valid (req_valid), .req_op (req_op),
        .req_addr (req_addr), .req_size (req_size), .req_wdata (req_wdata),
        .req_cond (req_cond), .req_cmp (req_cmp), .req_linked (req_linked),
        .rsp_done (rsp_done), .rsp_err (rsp_err), .rsp_data (rsp_data),
        .resv_valid (resv_valid), .resv_addr (resv_addr)
    );

    always #5 clk = ~clk;

    typedef struct {
        logic [63:0] data;
        bit          err;
        bit          resv;
        logic [31:0] addr;
        int          due;
        string       tag;
    } exp_t;

    exp_t       sb[$];
    logic [7:0] mdl [MEM];
    int         cyc = 0;
    int         checks = 0;
    int         fails = 0;
    bit         done_flag = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Driver: presents one request and pushes the expected response.
    task automatic issue(input logic [2:0] op, input logic [31:0] a, input logic [1:0] sz,
                         input logic [63:0] wd, input bit cnd, input logic [63:0] cmpv,
                         input bit lnk, input string tag);
        exp_t        e;
        int          nb;
        longint      rel;
        logic [63:0] old;
        bit          err, eq, wr;
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = a; req_size = sz;
        req_wdata = wd; req_cond = cnd; req_cmp = cmpv; req_linked = lnk;
        nb  = 1 << sz;
        rel = longint'(a) - longint'(BASE);
        err = (op > 3'd3) || (rel < 0) || (rel + nb > MEM) || ((a % nb) != 0) ||
              (op == 3'd3 && cnd && sz < 2);
        old = '0;
        if (!err) for (int j = 0; j < nb; j++) old[8*j +: 8] = mdl[int'(rel) + j];
        eq = (sz == 2'd3) ? (old == cmpv) : (old[31:0] == cmpv[31:0]);
        wr = !err && (op == 3'd1 || (op == 3'd3 && (!cnd || eq)));
        if (wr) for (int j = 0; j < nb; j++) mdl[int'(rel) + j] = wd[8*j +: 8];
        e.data = (!err && (op == 3'd0 || op == 3'd3)) ? old : 64'h0;
        e.err  = err;
        e.resv = !err && op == 3'd0 && lnk;
        e.addr = a;
        e.due  = cyc + LAT;
        e.tag  = tag;
        sb.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req_valid = 1'b0; req_linked = 1'b0; req_cond = 1'b0;
        end
    endtask

    task automatic rd(input logic [31:0] a, input logic [1:0] sz, input string tag);
        issue(3'd0, a, sz, 64'h0, 1'b0, 64'h0, 1'b0, tag);
    endtask

    // Monitor: pops and compares as responses appear.
    always @(negedge clk) begin
        if (!rst) begin
            if (resv_valid && !rsp_done)
                chk(1'b0, "R10", "resv without done", {63'h0, resv_valid}, 64'h0);
            if (rsp_done) begin
                if (sb.size() == 0) begin
                    chk(1'b0, "R8", "unexpected response", 64'h1, 64'h0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    chk(cyc == e.due, "R8", "response cycle", 64'(cyc), 64'(e.due));
                    chk(rsp_err == e.err, e.tag, "err", {63'h0, rsp_err}, {63'h0, e.err});
                    chk(rsp_data == e.data, e.tag, "data", rsp_data, e.data);
                    chk(resv_valid == e.resv, "R10", "resv flag",
                        {63'h0, resv_valid}, {63'h0, e.resv});
                    if (e.resv)
                        chk(resv_addr == e.addr, "R10", "resv addr",
                            {32'h0, resv_addr}, {32'h0, e.addr});
                end
            end else if (sb.size() != 0 && sb[0].due <= cyc) begin
                chk(1'b0, "R8", "missing response", 64'(cyc), 64'(sb[0].due));
                void'(sb.pop_front());
            end
        end
    end

    initial begin
        for (int i = 0; i < MEM; i++) mdl[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(rsp_done == 1'b0, "R9", "done after reset", {63'h0, rsp_done}, 64'h0);
        chk(resv_valid == 1'b0, "R10", "resv after reset", {63'h0, resv_valid}, 64'h0);

        // R9: cleared contents
        rd(BASE, 2'd3, "R9"); rd(BASE + 248, 2'd3, "R9"); rd(BASE + 100, 2'd2, "R9");
        idle(2);

        // R1 / R2: write then reads of every width
        issue(3'd1, BASE, 2'd3, 64'h1122_3344_5566_7788, 1'b0, 64'h0, 1'b0, "R2");
        idle(1);
        rd(BASE, 2'd0, "R1"); rd(BASE + 2, 2'd1, "R1");
        rd(BASE + 4, 2'd2, "R1"); rd(BASE, 2'd3, "R1");
        issue(3'd1, BASE + 1, 2'd0, 64'hFFFF_FFFF_FFFF_FFAA, 1'b0, 64'h0, 1'b0, "R2");
        issue(3'd1, BASE + 6, 2'd1, 64'hFFFF_FFFF_FFFF_BEEF, 1'b0, 64'h0, 1'b0, "R2");
        rd(BASE, 2'd3, "R2");
        idle(3);

        // R3: unconditional swaps, all sizes
        issue(3'd3, BASE + 16, 2'd3, 64'hA5A5_0000_1234_5678, 1'b0, 64'h0, 1'b0, "R3");
        issue(3'd3, BASE + 16, 2'd0, 64'h0000_0000_0000_00C3, 1'b0, 64'h0, 1'b0, "R3");
        issue(3'd3, BASE + 18, 2'd1, 64'h0000_0000_0000_9911, 1'b0, 64'h0, 1'b0, "R3");
        issue(3'd3, BASE + 20, 2'd2, 64'h0000_0000_CAFE_F00D, 1'b0, 64'h0, 1'b0, "R3");
        rd(BASE + 16, 2'd3, "R3");
        idle(2);

        // R4: conditional swaps, hit and miss, 8 and 4 bytes
        issue(3'd1, BASE + 32, 2'd3, 64'h0123_4567_89AB_CDEF, 1'b0, 64'h0, 1'b0, "R4");
        issue(3'd3, BASE + 32, 2'd3, 64'h1111_1111_1111_1111, 1'b1, 64'h0123_4567_89AB_CDEE, 1'b0, "R4");
        rd(BASE + 32, 2'd3, "R4");
        issue(3'd3, BASE + 32, 2'd3, 64'h2222_2222_2222_2222, 1'b1, 64'h0123_4567_89AB_CDEF, 1'b0, "R4");
        rd(BASE + 32, 2'd3, "R4");
        issue(3'd3, BASE + 36, 2'd2, 64'h0000_0000_3333_3333, 1'b1, 64'hDEAD_BEEF_2222_2222, 1'b0, "R4");
        issue(3'd3, BASE + 32, 2'd2, 64'h0000_0000_4444_4444, 1'b1, 64'h0000_0000_0000_0001, 1'b0, "R4");
        rd(BASE + 32, 2'd3, "R4");
        idle(2);

        // R5: conditional swap of 1 or 2 bytes is rejected
        issue(3'd3, BASE + 32, 2'd0, 64'h55, 1'b1, 64'h22, 1'b0, "R5");
        issue(3'd3, BASE + 32, 2'd1, 64'h5555, 1'b1, 64'h2222, 1'b0, "R5");
        rd(BASE + 32, 2'd3, "R5");
        idle(2);

        // R6: range and alignment errors
        issue(3'd1, BASE - 1, 2'd0, 64'h77, 1'b0, 64'h0, 1'b0, "R6");
        issue(3'd1, BASE + 252, 2'd3, 64'h7777_7777_7777_7777, 1'b0, 64'h0, 1'b0, "R6");
        rd(BASE + 256, 2'd0, "R6");
        issue(3'd1, BASE + 2, 2'd2, 64'h9999_9999, 1'b0, 64'h0, 1'b0, "R6");
        issue(3'd3, BASE + 17, 2'd1, 64'h8888, 1'b0, 64'h0, 1'b0, "R6");
        rd(BASE + 248, 2'd3, "R6"); rd(BASE, 2'd3, "R6"); rd(BASE + 16, 2'd3, "R6");
        idle(2);

        // R7: invalidate touches nothing
        issue(3'd2, BASE, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 64'h0, 1'b0, "R7");
        rd(BASE, 2'd3, "R7");
        idle(1);

        // R11: unsupported op codes
        issue(3'd5, BASE + 40, 2'd3, 64'hABCD, 1'b0, 64'h0, 1'b0, "R11");
        issue(3'd7, BASE + 40, 2'd3, 64'hABCD, 1'b0, 64'h0, 1'b0, "R11");
        rd(BASE + 40, 2'd3, "R11");
        idle(2);

        // R10: reservation pulses
        issue(3'd0, BASE + 16, 2'd2, 64'h0, 1'b0, 64'h0, 1'b1, "R10");
        issue(3'd1, BASE + 48, 2'd2, 64'h1234, 1'b0, 64'h0, 1'b1, "R10");
        issue(3'd0, BASE + 300, 2'd0, 64'h0, 1'b0, 64'h0, 1'b1, "R10");
        issue(3'd3, BASE + 48, 2'd2, 64'h5678, 1'b0, 64'h0, 1'b1, "R10");
        issue(3'd0, BASE + 255, 2'd0, 64'h0, 1'b0, 64'h0, 1'b1, "R10");
        idle(4);

        // R8: dependent back-to-back chain on one word
        issue(3'd1, BASE + 64, 2'd3, 64'h0000_0000_0000_0010, 1'b0, 64'h0, 1'b0, "R8");
        issue(3'd3, BASE + 64, 2'd3, 64'h0000_0000_0000_0020, 1'b0, 64'h0, 1'b0, "R8");
        issue(3'd3, BASE + 64, 2'd3, 64'h0000_0000_0000_0030, 1'b1, 64'h0000_0000_0000_0020, 1'b0, "R8");
        issue(3'd3, BASE + 64, 2'd3, 64'h0000_0000_0000_0040, 1'b1, 64'h0000_0000_0000_0020, 1'b0, "R8");
        rd(BASE + 64, 2'd3, "R8");
        issue(3'd1, BASE + 65, 2'd0, 64'h77, 1'b0, 64'h0, 1'b0, "R8");
        rd(BASE + 64, 2'd1, "R8");
        idle(LAT + 4);

        done_flag = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done_flag) begin
            checks++;
            fails++;
            $display("FAIL R8 watchdog actual=%0d expected=%0d", cyc, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule